// File: doc/BRIEF.md
# Backward State-Metric and Extrinsic Soft-Output Unit

This unit is the reverse half of a sliding-window soft-in soft-out decoder for an 8-state recursive systematic convolutional code. A controller replays one window at a time, one trellis step per clock, from the highest step index down to the lowest. Each step supplies the eight forward metrics that were stacked during the forward pass, together with the a-priori, systematic and parity soft inputs for that step. The unit forms the branch metrics and runs one backward add-compare-select update per state. It reuses the per-state branch-plus-next-metric sums from that update to build the two maximum trees of the extrinsic soft output, and returns the result scaled by three quarters.

The backward recursion of a window has to start from some value. On the first iteration it starts from all zeros. On later iterations it starts from the metrics that the window above produced at its lowest step in the previous iteration. These border values are kept in a small per-window buffer. Each result leaves the unit with its step index and the backward metrics of that step, so that a downstream writer can place it.

Top module: `bwd_llr_unit`

## Requirements
- R1: The state is a 3-bit number m; with r1=m[2], r2=m[1], r3=m[0] and input bit j, the feedback bit is a = j^r2^r3, the parity bit is p = a^r1^r3 and the next state is {a, r1, r2}. The branch metric of (j, m) is j*(apri+sys) + p*par, using signed inputs.
- R2: For each state m, the unnormalized backward metric is the larger of the two sums branch(j, m) + beta_next[next(j, m)] over j = 0 and j = 1.
- R3: The backward metrics are normalized by subtracting the unnormalized metric of state 0, then saturated to a signed MW-bit range. Normalized state 0 is therefore always 0. Metric of state m sits in bits [m*MW +: MW] of every metric vector.
- R4: On a step flagged as the first of a window, beta_next is all zeros if iter_first is 1 or if nothing has been stored for window in_win since reset. Otherwise it is the border value stored for window in_win. On all other steps, beta_next is the metrics produced by the previous accepted step.
- R5: On a step flagged as the last of a window with in_win > 0, the normalized metrics of that step are stored as the border value of window in_win-1. When in_win = 0 nothing is stored.
- R6: The raw soft output is the maximum over m of alpha[m] + sum(1, m), minus the maximum over m of alpha[m] + sum(0, m), where sum(j, m) is the branch-plus-next-metric term of R2.
- R7: The raw soft output x is scaled to x - (x >>> 2), with an arithmetic shift, and saturated to a signed OW-bit range.
- R8: Each accepted step produces exactly one output, with out_valid high two clock edges after the edge that accepts the input. out_idx equals that step's in_idx, and out_beta holds that step's normalized metrics.
- R9: While in_valid is low, all other inputs are ignored: no output appears and the recursion state is kept for the next step.
- R10: Reset clears out_valid and the recursion state, and marks every border entry as empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A step is presented this cycle |
| in_first | input | 1 | Step is the highest index of its window |
| in_last | input | 1 | Step is the lowest index of its window |
| iter_first | input | 1 | First decoding iteration: window start uses zeros |
| in_win | input | $clog2(NWIN) | Window number of the step |
| in_idx | input | IW | Step index |
| in_alpha | input | 8*MW | Forward metrics of the step, signed, state m at [m*MW +: MW] |
| in_apri | input | LW | Signed a-priori soft input |
| in_sys | input | LW | Signed systematic soft input |
| in_par | input | LW | Signed parity soft input |
| out_valid | output | 1 | Result valid |
| out_idx | output | IW | Step index of the result |
| out_llr | output | OW | Scaled, saturated extrinsic soft output, signed |
| out_beta | output | 8*MW | Normalized backward metrics of the step |

## Verification
All three results of a step (soft output, index and backward metrics) are due at the second rising edge after the edge that accepts the step. The bench reads them at the falling edge that follows. It stamps each expected entry with the cycle count at which it must appear and compares that stamp with the count at which it does appear, so both an early result and a late one are flagged. Idle cycles carry random data on every input, and the bench checks them twice: no output may appear, and the next result must still follow from the recursion state held before the gap. Window lengths include single-step windows, where the first and last flags coincide. Forward metrics are run both small and near full scale, so that metric and output saturation are both exercised.

// File: rtl/bwd_llr_pkg.sv
package bwd_llr_pkg;
  localparam int NS = 8;

  // trellis successor for state m under input bit j
  function automatic logic [2:0] nxt_state(input logic [2:0] m, input logic j);
    logic fb;
    fb = j ^ m[1] ^ m[0];
    return {fb, m[2], m[1]};
  endfunction

  // parity bit emitted on the transition (j, m)
  function automatic logic par_bit(input logic [2:0] m, input logic j);
    logic fb;
    fb = j ^ m[1] ^ m[0];
    return fb ^ m[2] ^ m[0];
  endfunction
endpackage

// File: rtl/bwd_acs_array.sv
module bwd_acs_array
  import bwd_llr_pkg::*;
#(
  parameter int MW = 10,
  parameter int GW = 7,
  parameter int SW = 12
) (
  input  logic [NS*MW-1:0]     beta_nxt,
  input  logic signed [GW-1:0] g_sys,
  input  logic signed [GW-1:0] g_par,
  output logic [NS*SW-1:0]     sum0,
  output logic [NS*SW-1:0]     sum1,
  output logic [NS*MW-1:0]     beta_cur
);
  localparam int DW = SW + 1;
  localparam logic signed [DW-1:0] BMAX = DW'((1 << (MW-1)) - 1);
  localparam logic signed [DW-1:0] BMIN = -BMAX - DW'(1);
  localparam logic signed [SW-1:0] ZS = '0;

  logic signed [SW-1:0] bx [NS];
  logic signed [SW-1:0] mx [NS];
  logic signed [SW-1:0] gs, gp;

  assign gs = SW'(g_sys);
  assign gp = SW'(g_par);

  for (genvar m = 0; m < NS; m++) begin : g_cell
    localparam logic [2:0] N0 = nxt_state(3'(m), 1'b0);
    localparam logic [2:0] N1 = nxt_state(3'(m), 1'b1);
    localparam logic       P0 = par_bit(3'(m), 1'b0);
    localparam logic       P1 = par_bit(3'(m), 1'b1);
    logic signed [SW-1:0] s0, s1;
    logic signed [DW-1:0] df;

    assign bx[m] = SW'($signed(beta_nxt[m*MW +: MW]));
    assign s0 = (P0 ? gp : ZS) + bx[N0];
    assign s1 = gs + (P1 ? gp : ZS) + bx[N1];
    assign mx[m] = (s1 > s0) ? s1 : s0;
    assign sum0[m*SW +: SW] = s0;
    assign sum1[m*SW +: SW] = s1;

    // normalize against state 0 and clamp to metric width
    assign df = DW'(mx[m]) - DW'(mx[0]);
    assign beta_cur[m*MW +: MW] = (df > BMAX) ? MW'(BMAX) :
                                  (df < BMIN) ? MW'(BMIN) : MW'(df);
  end
endmodule

// File: rtl/bwd_llr_stage.sv
module bwd_llr_stage
  import bwd_llr_pkg::*;
#(
  parameter int MW = 10,
  parameter int SW = 12,
  parameter int OW = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [NS*MW-1:0]    alpha,
  input  logic [NS*SW-1:0]    sum0,
  input  logic [NS*SW-1:0]    sum1,
  output logic                mid_valid,
  output logic                out_valid,
  output logic [OW-1:0]       out_llr
);
  localparam int PW = SW + 1;
  localparam int DW = PW + 1;
  localparam logic signed [DW-1:0] LMAX = DW'((1 << (OW-1)) - 1);
  localparam logic signed [DW-1:0] LMIN = -LMAX - DW'(1);

  typedef logic signed [PW-1:0] pv_t [NS];

  pv_t p0_q, p1_q;
  logic signed [PW-1:0] mx0, mx1;
  logic signed [DW-1:0] diff, scl;

  // three-level comparison tree
  function automatic logic signed [PW-1:0] tree_max(input pv_t v);
    logic signed [PW-1:0] l1 [4];
    logic signed [PW-1:0] l2 [2];
    for (int i = 0; i < 4; i++) l1[i] = (v[2*i] > v[2*i+1]) ? v[2*i] : v[2*i+1];
    for (int i = 0; i < 2; i++) l2[i] = (l1[2*i] > l1[2*i+1]) ? l1[2*i] : l1[2*i+1];
    return (l2[0] > l2[1]) ? l2[0] : l2[1];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) mid_valid <= 1'b0;
    else     mid_valid <= in_valid;
    if (in_valid) begin
      for (int m = 0; m < NS; m++) begin
        p0_q[m] <= PW'($signed(alpha[m*MW +: MW])) + PW'($signed(sum0[m*SW +: SW]));
        p1_q[m] <= PW'($signed(alpha[m*MW +: MW])) + PW'($signed(sum1[m*SW +: SW]));
      end
    end
  end

  always_comb begin
    mx0  = tree_max(p0_q);
    mx1  = tree_max(p1_q);
    diff = DW'(mx1) - DW'(mx0);
    scl  = diff - (diff >>> 2);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_llr   <= '0;
    end else begin
      out_valid <= mid_valid;
      if (mid_valid)
        out_llr <= (scl > LMAX) ? OW'(LMAX) : (scl < LMIN) ? OW'(LMIN) : OW'(scl);
    end
  end

  // scaling and clamping keep the sign of the metric difference
  p_pos_sign_r7: assert property (@(posedge clk) disable iff (rst)
    mid_valid |=> (($signed(out_llr) > 0) -> ($past(diff) > 0)));
  p_neg_sign_r7: assert property (@(posedge clk) disable iff (rst)
    mid_valid |=> (($signed(out_llr) < 0) -> ($past(diff) < 0)));
endmodule

// File: rtl/bwd_border_buf.sv
module bwd_border_buf #(
  parameter int DWID = 80,
  parameter int NWIN = 4,
  parameter int AW   = $clog2(NWIN)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DWID-1:0] wr_data,
  input  logic [AW-1:0]   rd_addr,
  output logic [DWID-1:0] rd_data,
  output logic            rd_hit
);
  logic [DWID-1:0] mem [NWIN];
  logic [NWIN-1:0] vld;

  // distributed RAM: synchronous write, asynchronous read
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst)        vld <= '0;
    else if (wr_en) vld[wr_addr] <= 1'b1;
  end

  assign rd_data = mem[rd_addr];
  assign rd_hit  = vld[rd_addr];

  p_fill_r5: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> vld[$past(wr_addr)]);
endmodule

// File: rtl/bwd_llr_unit.sv
module bwd_llr_unit
  import bwd_llr_pkg::*;
#(
  parameter int MW   = 10,
  parameter int LW   = 6,
  parameter int OW   = 8,
  parameter int IW   = 13,
  parameter int NWIN = 4,
  parameter int WINW = $clog2(NWIN)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic               in_first,
  input  logic               in_last,
  input  logic               iter_first,
  input  logic [WINW-1:0]    in_win,
  input  logic [IW-1:0]      in_idx,
  input  logic [NS*MW-1:0]   in_alpha,
  input  logic [LW-1:0]      in_apri,
  input  logic [LW-1:0]      in_sys,
  input  logic [LW-1:0]      in_par,
  output logic               out_valid,
  output logic [IW-1:0]      out_idx,
  output logic [OW-1:0]      out_llr,
  output logic [NS*MW-1:0]   out_beta
);
  localparam int GW = LW + 2;
  localparam int SW = MW + 2;

  logic signed [GW-1:0] g_sys, g_par;
  logic [NS*MW-1:0] beta_reg, beta_src, beta_new, brd_data;
  logic [NS*SW-1:0] sum0, sum1;
  logic             brd_hit, mid_valid, brd_we;
  logic [IW-1:0]    idx_mid;

  assign g_sys = GW'($signed(in_apri)) + GW'($signed(in_sys));
  assign g_par = GW'($signed(in_par));

  assign beta_src = !in_first ? beta_reg :
                    (iter_first || !brd_hit) ? '0 : brd_data;

  bwd_acs_array #(.MW(MW), .GW(GW), .SW(SW)) u_acs (
    .beta_nxt(beta_src), .g_sys(g_sys), .g_par(g_par),
    .sum0(sum0), .sum1(sum1), .beta_cur(beta_new)
  );

  assign brd_we = in_valid && in_last && (in_win != '0);

  bwd_border_buf #(.DWID(NS*MW), .NWIN(NWIN), .AW(WINW)) u_brd (
    .clk(clk), .rst(rst), .wr_en(brd_we), .wr_addr(in_win - WINW'(1)),
    .wr_data(beta_new), .rd_addr(in_win), .rd_data(brd_data), .rd_hit(brd_hit)
  );

  bwd_llr_stage #(.MW(MW), .SW(SW), .OW(OW)) u_llr (
    .clk(clk), .rst(rst), .in_valid(in_valid), .alpha(in_alpha),
    .sum0(sum0), .sum1(sum1), .mid_valid(mid_valid),
    .out_valid(out_valid), .out_llr(out_llr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      beta_reg <= '0;
      idx_mid  <= '0;
      out_idx  <= '0;
      out_beta <= '0;
    end else begin
      if (in_valid) begin
        beta_reg <= beta_new;
        idx_mid  <= in_idx;
      end
      if (mid_valid) begin
        out_idx  <= idx_mid;
        out_beta <= beta_reg;
      end
    end
  end

  p_latency_r8: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##2 out_valid);
  p_index_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_idx == $past(in_idx, 2)));
  p_origin_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 2));
  p_state0_zero_r3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_beta[MW-1:0] == '0));
endmodule

// File: tb/bwd_llr_unit_test.sv
module bwd_llr_unit_test;
  localparam int MW = 10, LW = 6, OW = 8, IW = 13, NWIN = 4, WINW = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 0, in_first = 0, in_last = 0, iter_first = 0;
  logic [WINW-1:0] in_win = '0;
  logic [IW-1:0] in_idx = '0;
  logic [8*MW-1:0] in_alpha = '0;
  logic [LW-1:0] in_apri = '0, in_sys = '0, in_par = '0;
  logic out_valid;
  logic [IW-1:0] out_idx;
  logic [OW-1:0] out_llr;
  logic [8*MW-1:0] out_beta;

  bwd_llr_unit #(.MW(MW), .LW(LW), .OW(OW), .IW(IW), .NWIN(NWIN)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_first(in_first), .in_last(in_last),
    .iter_first(iter_first), .in_win(in_win), .in_idx(in_idx), .in_alpha(in_alpha),
    .in_apri(in_apri), .in_sys(in_sys), .in_par(in_par), .out_valid(out_valid),
    .out_idx(out_idx), .out_llr(out_llr), .out_beta(out_beta));

  always #5 clk = ~clk;

  int cyc = 0, n_chk = 0, n_fail = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // reference state
  int bstate [8];
  int border [NWIN][8];
  bit bvld [NWIN];
  bit after_gap = 0, after_rst2 = 0;

  int q_cyc[$], q_idx[$], q_llr[$];
  logic [8*MW-1:0] q_beta[$];
  string q_tag[$];

  function automatic int clamp(int x, int lo, int hi);
    return (x > hi) ? hi : (x < lo) ? lo : x;
  endfunction

  function automatic int sx(logic [LW-1:0] v);
    return int'($signed(v));
  endfunction

  task automatic check(bit ok, string req, int act, int exp, string what);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    in_valid = 0;
    in_first = $urandom_range(0, 1); in_last = $urandom_range(0, 1);
    iter_first = $urandom_range(0, 1);
    in_win = WINW'($urandom); in_idx = IW'($urandom);
    in_alpha = {$urandom, $urandom, $urandom};
    in_apri = LW'($urandom); in_sys = LW'($urandom); in_par = LW'($urandom);
  endtask

  task automatic drive_step(bit first, bit last, bit itf, int win, int idx, int amag);
    int al [8];
    int bn [8];
    int s [2][8];
    int mxm [8];
    int nb [8];
    int gs, gp, m1, m0, d, sc;
    logic [8*MW-1:0] pk;
    string tag;
    @(negedge clk);
    in_valid = 1; in_first = first; in_last = last; iter_first = itf;
    in_win = WINW'(win); in_idx = IW'(idx);
    for (int m = 0; m < 8; m++) begin
      al[m] = int'($urandom_range(0, 2*amag)) - amag;
      in_alpha[m*MW +: MW] = MW'(al[m]);
    end
    in_apri = LW'(int'($urandom_range(0, 62)) - 31);
    in_sys  = LW'(int'($urandom_range(0, 62)) - 31);
    in_par  = LW'(int'($urandom_range(0, 62)) - 31);
    gs = sx(in_apri) + sx(in_sys);
    gp = sx(in_par);
    for (int m = 0; m < 8; m++)
      bn[m] = !first ? bstate[m] : ((itf || !bvld[win]) ? 0 : border[win][m]);
    for (int m = 0; m < 8; m++) begin
      for (int j = 0; j < 2; j++) begin
        int r1, r2, r3, a, p, n;
        r1 = (m >> 2) & 1; r2 = (m >> 1) & 1; r3 = m & 1;
        a = j ^ r2 ^ r3; p = a ^ r1 ^ r3; n = (a << 2) | (r1 << 1) | r2;
        s[j][m] = (j ? gs : 0) + (p ? gp : 0) + bn[n];
      end
      mxm[m] = (s[1][m] > s[0][m]) ? s[1][m] : s[0][m];
    end
    m1 = -1000000; m0 = -1000000;
    for (int m = 0; m < 8; m++) begin
      nb[m] = clamp(mxm[m] - mxm[0], -(2**(MW-1)), 2**(MW-1) - 1);
      pk[m*MW +: MW] = MW'(nb[m]);
      if (al[m] + s[1][m] > m1) m1 = al[m] + s[1][m];
      if (al[m] + s[0][m] > m0) m0 = al[m] + s[0][m];
    end
    d = m1 - m0;
    sc = d - (d >>> 2);
    if (last && win != 0) begin
      for (int m = 0; m < 8; m++) border[win-1][m] = nb[m];
      bvld[win-1] = 1;
    end
    for (int m = 0; m < 8; m++) bstate[m] = nb[m];
    if (after_rst2 && first) tag = "R10 R4";
    else if (first) tag = itf ? "R4" : "R4 R5";
    else if (after_gap) tag = "R9 R2";
    else tag = "R2";
    after_gap = 0;
    q_cyc.push_back(cyc + 2); q_idx.push_back(idx);
    q_llr.push_back(clamp(sc, -(2**(OW-1)), 2**(OW-1) - 1));
    q_beta.push_back(pk); q_tag.push_back(tag);
  endtask

  task automatic run_window(int win, int len, bit itf, int amag, bit gaps);
    for (int s = len - 1; s >= 0; s--) begin
      drive_step(s == len - 1, s == 0, itf, win, win * len + s, amag);
      if (gaps && (s % 3 == 1)) begin
        idle_cycle();
        after_gap = 1;
      end
    end
  endtask

  task automatic run_iter(int len, bit itf, int amag, bit gaps);
    for (int w = NWIN - 1; w >= 0; w--) run_window(w, len, itf, amag, gaps);
    idle_cycle();
  endtask

  task automatic drain();
    while (q_cyc.size() != 0) idle_cycle();
    repeat (3) idle_cycle();
  endtask

  // per-cycle comparison against the reference queue
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (out_valid) begin
        if (q_cyc.size() == 0) begin
          check(0, "R9", 1, 0, "unexpected out_valid");
        end else begin
          string t;
          t = q_tag.pop_front();
          check(q_cyc[0] == cyc, "R8", cyc, q_cyc[0], "output cycle");
          check(int'(out_idx) == q_idx[0], "R8", int'(out_idx), q_idx[0], "out_idx");
          check(int'($signed(out_llr)) == q_llr[0], {"R1 R6 R7 ", t},
                int'($signed(out_llr)), q_llr[0], "out_llr");
          for (int m = 0; m < 8; m++)
            check(out_beta[m*MW +: MW] == q_beta[0][m*MW +: MW], {"R3 ", t},
                  int'($signed(out_beta[m*MW +: MW])),
                  int'($signed(q_beta[0][m*MW +: MW])), "out_beta");
          void'(q_cyc.pop_front()); void'(q_idx.pop_front());
          void'(q_llr.pop_front()); void'(q_beta.pop_front());
        end
      end else if (q_cyc.size() != 0 && q_cyc[0] <= cyc) begin
        check(0, "R8", 0, 1, "missing out_valid");
        void'(q_cyc.pop_front()); void'(q_idx.pop_front());
        void'(q_llr.pop_front()); void'(q_beta.pop_front()); void'(q_tag.pop_front());
      end
    end
  end

  task automatic finish_up();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "watchdog", cyc, 0, "run did not finish");
    finish_up();
  end

  initial begin
    for (int w = 0; w < NWIN; w++) bvld[w] = 0;
    for (int m = 0; m < 8; m++) bstate[m] = 0;
    repeat (3) @(negedge clk);
    check(out_valid == 0, "R10", int'(out_valid), 0, "out_valid in reset");
    rst = 0;
    idle_cycle();
    check(out_valid == 0, "R10", int'(out_valid), 0, "out_valid after reset");
    run_iter(8, 1, 40, 1);    // first iteration, small metrics, gaps
    run_iter(8, 0, 40, 1);    // border reuse
    run_iter(8, 0, 500, 0);   // near full scale, saturation
    run_iter(1, 0, 60, 0);    // single-step windows
    drain();
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk);
    check(out_valid == 0, "R10", int'(out_valid), 0, "out_valid in second reset");
    rst = 0;
    for (int w = 0; w < NWIN; w++) bvld[w] = 0;
    for (int m = 0; m < 8; m++) bstate[m] = 0;
    after_rst2 = 1;
    run_iter(6, 0, 80, 1);    // borders must read as empty
    after_rst2 = 0;
    run_iter(6, 0, 80, 0);
    drain();
    finish_up();
  end
endmodule